// File: doc/BRIEF.md
# Paged Register Bus Decoder

This block sits between a host bus and the register space of an Ethernet controller core that keeps a legacy-compatible register map. Each clock cycle the host may present a 10-bit address with a read strobe, a write strobe, or both. Every cycle in which a strobe is high counts as one access. The block decides whether the access belongs to this device, either by address alone or by address qualified with an active-low chip select. It then routes the access to the command register, to one of two pages of byte-wide registers, or to a two-byte data-port window that feeds the buffer DMA logic.

The upper five address bits must equal the upper bits of one of eight base addresses, chosen by a 3-bit select input. The low five bits pick one of 32 device offsets. Offset 00h is the command register on every page. Its two top bits choose which page answers offsets 01h–0Fh. Offsets 10h and 11h form the data port. They raise a strobe toward the DMA logic and leave the register file untouched. Read data is combinational and is valid in the cycle of the read strobe. Writes land on the next rising clock edge.

Top module: `pgreg_decode`

## Requirements
- R1: The device is hit only when address bits 9:5 equal bits 9:5 of the base picked by `base_sel`. The bases are 300h, 320h, 340h, 360h, 380h, 3A0h and 3C0h for select values 0 to 6, and 200h for select value 7. With select 7 the device answers 200h–21Fh.
- R2: With `cs_qual` = 1, a hit also needs `host_cs_n` = 0, and the upper address bits must still match as in R1. With `cs_qual` = 0, `host_cs_n` has no effect on the hit.
- R3: Offset 00h reaches the 8-bit command register whatever page is selected. It reads back the last value written to it.
- R4: Command bits 7:6 select the page for offsets 01h–0Fh: 00 selects page 0 and 01 selects page 1. With 10 or 11, reads of 01h–0Fh return 00h and writes to them are discarded.
- R5: Page 0 holds 15 read/write byte registers at offsets 01h–0Fh. They are separate from page 1.
- R6: Page 1 holds read/write byte registers at offsets 01h–07h. Its offsets 08h–0Fh read 00h and discard writes.
- R7: A hit read at 10h or 11h raises `dp_rd_stb` for that cycle and returns `dp_rd_data` on `host_rdata`. A hit write there raises `dp_wr_stb`. `dp_hi` carries address bit 0 while either strobe is high and is 0 otherwise. Data-port accesses change no register.
- R8: Offsets 12h–1Fh read 00h, discard writes and raise no data-port strobe.
- R9: An access that misses changes no register, raises no strobe and reads 00h. `host_rdata` is also 00h in every cycle without a hit read.
- R10: After reset the command register is 00h, which selects page 0, and every page register is 00h.
- R11: When both strobes are high in one cycle, the read returns the value held before that cycle's write, and the write is stored at the clock edge.
- R12: A write takes effect at the next rising edge. A page change made by a command write applies to accesses from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 10 | Host address; bits 9:5 match the base, bits 4:0 select the offset |
| host_cs_n | input | 1 | Active-low chip select, used when `cs_qual` is 1 |
| base_sel | input | 3 | Selects one of eight base addresses |
| cs_qual | input | 1 | 1: a hit also needs chip select; 0: address-only matching |
| host_rd | input | 1 | Read strobe, one access per high cycle |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the read cycle |
| dev_hit | output | 1 | Address (and chip select, when used) select this device |
| dp_rd_data | input | 8 | Byte from the buffer DMA logic for data-port reads |
| dp_rd_stb | output | 1 | Data-port read pulse toward the DMA logic |
| dp_wr_stb | output | 1 | Data-port write pulse toward the DMA logic |
| dp_hi | output | 1 | Which data-port byte (address bit 0) while a strobe is high |
| cmd_q | output | 8 | Current command register value |

## Verification
Two things can fall in the same cycle. A read and a write can both be strobed at one offset. A command write that changes the page can also be followed at once by a paged access. The bench provokes the first by raising both strobes at offset 00h and at a page-0 offset. It judges that the read shows the old byte and that the written byte appears in the following cycle. For the second, it writes the command register and accesses a paged offset in the very next cycle. A reference model, which uses the page only from the cycle after the write, must agree with the design on every clock.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int HOST_AW     = 10;
  localparam int OFF_W       = 5;
  localparam int UP_W        = HOST_AW - OFF_W;
  localparam int DATA_W      = 8;
  localparam int SEL_W       = 3;
  localparam int PAGE_SLOTS  = 16;
  localparam int IDX_W       = $clog2(PAGE_SLOTS);
  localparam int DPORT_FIRST = 16;
  localparam int DPORT_SLOTS = 2;
  localparam int PAGE_MSB    = 7;
  localparam int PAGE_LSB    = 6;
  localparam logic [1:0] PAGE0_CODE = 2'b00;
  localparam logic [1:0] PAGE1_CODE = 2'b01;

  typedef enum logic [1:0] {OC_CMD, OC_PAGED, OC_DPORT, OC_RSVD} off_class_e;

  // Upper address bits of the selected base. Codes 0..6 step upward from 300h
  // in 20h strides; code 7 is the lower alternative at 200h.
  function automatic logic [UP_W-1:0] base_upper(input logic [SEL_W-1:0] sel);
    if (sel == '1) return UP_W'(5'h10);
    return UP_W'(5'h18) + UP_W'(sel);
  endfunction

  function automatic off_class_e classify(input logic [OFF_W-1:0] off);
    if (off == '0) return OC_CMD;
    if (off < OFF_W'(PAGE_SLOTS)) return OC_PAGED;
    if (off < OFF_W'(DPORT_FIRST + DPORT_SLOTS)) return OC_DPORT;
    return OC_RSVD;
  endfunction
endpackage

// File: rtl/pgreg_match.sv
module pgreg_match
  import pgreg_pkg::*;
(
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [SEL_W-1:0]   base_sel,
  input  logic               host_cs_n,
  input  logic               cs_qual,
  output logic               addr_match,
  output logic               dev_hit
);
  logic [UP_W-1:0] want_upper;
  logic            cs_ok;

  assign want_upper = base_upper(base_sel);
  assign addr_match = (host_addr[HOST_AW-1:OFF_W] == want_upper);
  // address-only mode ignores the chip select entirely
  assign cs_ok      = cs_qual ? ~host_cs_n : 1'b1;
  assign dev_hit    = addr_match & cs_ok;
endmodule

// File: rtl/pgreg_offset_dec.sv
module pgreg_offset_dec
  import pgreg_pkg::*;
#(
  parameter int P1_IMPL = 8
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       page_bits,
  input  logic             acc_rd,
  input  logic             acc_wr,
  output logic             cmd_rd,
  output logic             cmd_wr,
  output logic             p0_rd,
  output logic             p0_wr,
  output logic             p1_rd,
  output logic             p1_wr,
  output logic             dp_rd,
  output logic             dp_wr,
  output logic             dp_hi,
  output logic [IDX_W-1:0] idx
);
  off_class_e oc;
  logic       on_p0;
  logic       on_p1;
  logic       p1_live;

  assign oc      = classify(off);
  assign idx     = off[IDX_W-1:0];
  assign on_p0   = (oc == OC_PAGED) && (page_bits == PAGE0_CODE);
  assign p1_live = int'(idx) < P1_IMPL;
  assign on_p1   = (oc == OC_PAGED) && (page_bits == PAGE1_CODE) && p1_live;

  assign cmd_rd = acc_rd && (oc == OC_CMD);
  assign cmd_wr = acc_wr && (oc == OC_CMD);
  assign p0_rd  = acc_rd && on_p0;
  assign p0_wr  = acc_wr && on_p0;
  assign p1_rd  = acc_rd && on_p1;
  assign p1_wr  = acc_wr && on_p1;
  assign dp_rd  = acc_rd && (oc == OC_DPORT);
  assign dp_wr  = acc_wr && (oc == OC_DPORT);
  assign dp_hi  = (dp_rd || dp_wr) && off[0];
endmodule

// File: rtl/pgreg_file.sv
module pgreg_file
  import pgreg_pkg::*;
#(
  parameter int P1_IMPL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_wr,
  input  logic              p0_wr,
  input  logic              p1_wr,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] p0_rdata,
  output logic [DATA_W-1:0] p1_rdata
);
  logic [DATA_W-1:0] p0_view [PAGE_SLOTS];
  logic [DATA_W-1:0] p1_view [PAGE_SLOTS];

  // reset value zero puts the page field on page 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= wdata;
  end

  for (genvar g = 0; g < PAGE_SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_cmd_hole
      // slot 0 is the command register, held above
      assign p0_view[g] = '0;
      assign p1_view[g] = '0;
    end else begin : g_live
      logic [DATA_W-1:0] p0_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          p0_q <= '0;
        else if (p0_wr && idx == IDX_W'(g))  p0_q <= wdata;
      end
      assign p0_view[g] = p0_q;

      if (g < P1_IMPL) begin : g_p1
        logic [DATA_W-1:0] p1_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                          p1_q <= '0;
          else if (p1_wr && idx == IDX_W'(g))  p1_q <= wdata;
        end
        assign p1_view[g] = p1_q;
      end else begin : g_p1_void
        assign p1_view[g] = '0;
      end
    end
  end

  assign p0_rdata = p0_view[idx];
  assign p1_rdata = p1_view[idx];
endmodule

// File: rtl/pgreg_decode.sv
module pgreg_decode
  import pgreg_pkg::*;
#(
  parameter int P1_IMPL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_cs_n,
  input  logic [SEL_W-1:0]   base_sel,
  input  logic               cs_qual,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               dev_hit,
  input  logic [DATA_W-1:0]  dp_rd_data,
  output logic               dp_rd_stb,
  output logic               dp_wr_stb,
  output logic               dp_hi,
  output logic [DATA_W-1:0]  cmd_q
);
  logic              addr_match;
  logic              acc_rd;
  logic              acc_wr;
  logic              cmd_rd;
  logic              cmd_wr;
  logic              p0_rd;
  logic              p0_wr;
  logic              p1_rd;
  logic              p1_wr;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] p0_rdata;
  logic [DATA_W-1:0] p1_rdata;

  pgreg_match u_match (
    .host_addr (host_addr),
    .base_sel  (base_sel),
    .host_cs_n (host_cs_n),
    .cs_qual   (cs_qual),
    .addr_match(addr_match),
    .dev_hit   (dev_hit)
  );

  assign acc_rd = host_rd && dev_hit;
  assign acc_wr = host_wr && dev_hit;

  pgreg_offset_dec #(.P1_IMPL(P1_IMPL)) u_dec (
    .off      (host_addr[OFF_W-1:0]),
    .page_bits(cmd_q[PAGE_MSB:PAGE_LSB]),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .p0_rd    (p0_rd),
    .p0_wr    (p0_wr),
    .p1_rd    (p1_rd),
    .p1_wr    (p1_wr),
    .dp_rd    (dp_rd_stb),
    .dp_wr    (dp_wr_stb),
    .dp_hi    (dp_hi),
    .idx      (idx)
  );

  pgreg_file #(.P1_IMPL(P1_IMPL)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (idx),
    .wdata   (host_wdata),
    .cmd_wr  (cmd_wr),
    .p0_wr   (p0_wr),
    .p1_wr   (p1_wr),
    .cmd_q   (cmd_q),
    .p0_rdata(p0_rdata),
    .p1_rdata(p1_rdata)
  );

  // read strobes from the decoder are mutually exclusive; anything else reads zero
  always_comb begin
    host_rdata = '0;
    if (cmd_rd)         host_rdata = cmd_q;
    else if (p0_rd)     host_rdata = p0_rdata;
    else if (p1_rd)     host_rdata = p1_rdata;
    else if (dp_rd_stb) host_rdata = dp_rd_data;
  end
endmodule

// File: rtl/pgreg_decode_chk.sv
module pgreg_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] host_addr,
  input logic       host_cs_n,
  input logic [2:0] base_sel,
  input logic       cs_qual,
  input logic       host_rd,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       dev_hit,
  input logic       dp_rd_stb,
  input logic       dp_wr_stb,
  input logic [7:0] cmd_q,
  input logic       cmd_wr,
  input logic       p0_wr,
  input logic       p1_wr
);
  // R1
  alt_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit && base_sel == 3'd7) |-> host_addr[9:5] == 5'h10);

  // R2
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_qual && host_cs_n) |-> !dev_hit);

  // R4
  p1_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p1_wr |-> cmd_q[7:6] == 2'b01);

  // R4
  p0_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_wr |-> cmd_q[7:6] == 2'b00);

  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr, p0_wr, p1_wr, dp_wr_stb}));

  // R8
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit && host_addr[4:0] >= 5'h12) |->
      (!dp_rd_stb && !dp_wr_stb && host_rdata == 8'h00 && !p0_wr && !p1_wr && !cmd_wr));

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_hit |-> (host_rdata == 8'h00 && !dp_rd_stb && !dp_wr_stb && !cmd_wr && !p0_wr && !p1_wr));

  // R11
  rw_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_rd) |-> host_rdata == cmd_q);

  // R12
  cmd_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_q == $past(host_wdata));
endmodule

bind pgreg_decode pgreg_decode_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_addr (host_addr),
  .host_cs_n (host_cs_n),
  .base_sel  (base_sel),
  .cs_qual   (cs_qual),
  .host_rd   (host_rd),
  .host_wdata(host_wdata),
  .host_rdata(host_rdata),
  .dev_hit   (dev_hit),
  .dp_rd_stb (dp_rd_stb),
  .dp_wr_stb (dp_wr_stb),
  .cmd_q     (cmd_q),
  .cmd_wr    (cmd_wr),
  .p0_wr     (p0_wr),
  .p1_wr     (p1_wr)
);

// File: tb/sim_pgreg_decode.sv
module sim_pgreg_decode;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] host_addr;
  logic       host_cs_n;
  logic [2:0] base_sel;
  logic       cs_qual;
  logic       host_rd;
  logic       host_wr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       dev_hit;
  logic [7:0] dp_rd_data;
  logic       dp_rd_stb;
  logic       dp_wr_stb;
  logic       dp_hi;
  logic [7:0] cmd_q;

  always #10 clk = ~clk;

  pgreg_decode u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_cs_n(host_cs_n),
    .base_sel(base_sel), .cs_qual(cs_qual), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dev_hit(dev_hit),
    .dp_rd_data(dp_rd_data), .dp_rd_stb(dp_rd_stb), .dp_wr_stb(dp_wr_stb),
    .dp_hi(dp_hi), .cmd_q(cmd_q)
  );

  int checks = 0;
  int failures = 0;
  // behavioural model state
  int m_cmd = 0;
  int m_p0[16];
  int m_p1[16];
  localparam int P1_LIVE = 8;
  int base_tab[8] = '{'h300, 'h320, 'h340, 'h360, 'h380, 'h3A0, 'h3C0, 'h200};
  int cur_sel = 0;
  bit cur_csq = 1'b0;
  int dp_pat = 'h3C;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input int exp);
    checks++;
    if (act !== 16'(exp)) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int base_of(input int sel);
    return base_tab[sel];
  endfunction

  // one host cycle: drive at the falling edge, compare mid-cycle, update model at the rising edge
  task automatic cyc(input int a, input bit rd, input bit wr, input int wd, input bit csn, input string tag);
    bit hit;
    int off, pg, erd, edr, edw, ehi;
    @(negedge clk);
    dp_pat = (dp_pat * 7 + 3) % 256;
    host_addr = 10'(a); host_rd = rd; host_wr = wr; host_wdata = 8'(wd);
    host_cs_n = csn; base_sel = 3'(cur_sel); cs_qual = cur_csq; dp_rd_data = 8'(dp_pat);
    #5;
    hit = ((a & 'h3E0) == base_tab[cur_sel]) && (!cur_csq || !csn);
    off = a % 32;
    pg  = m_cmd / 64;
    erd = 0;
    if (hit && rd) begin
      if (off == 0) erd = m_cmd;
      else if (off < 16) begin
        if (pg == 0) erd = m_p0[off];
        else if (pg == 1 && off < P1_LIVE) erd = m_p1[off];
      end else if (off < 18) erd = dp_pat;
    end
    edr = (hit && rd && off >= 16 && off < 18) ? 1 : 0;
    edw = (hit && wr && off >= 16 && off < 18) ? 1 : 0;
    ehi = (edr + edw > 0) ? off % 2 : 0;
    chk(tag, "dev_hit", 16'(dev_hit), int'(hit));
    chk(tag, "host_rdata", 16'(host_rdata), erd);
    chk(tag, "dp_rd_stb", 16'(dp_rd_stb), edr);
    chk(tag, "dp_wr_stb", 16'(dp_wr_stb), edw);
    chk(tag, "dp_hi", 16'(dp_hi), ehi);
    chk(tag, "cmd_q", 16'(cmd_q), m_cmd);
    @(posedge clk);
    if (hit && wr) begin
      if (off == 0) m_cmd = wd % 256;
      else if (off < 16) begin
        if (pg == 0) m_p0[off] = wd % 256;
        else if (pg == 1 && off < P1_LIVE) m_p1[off] = wd % 256;
      end
    end
  endtask

  task automatic rd_at(input int a, input string tag);
    cyc(a, 1'b1, 1'b0, 0, 1'b0, tag);
  endtask

  task automatic wr_at(input int a, input int d, input string tag);
    cyc(a, 1'b0, 1'b1, d, 1'b0, tag);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int b;
    for (int i = 0; i < 16; i++) begin m_p0[i] = 0; m_p1[i] = 0; end
    rst_n = 1'b0; host_addr = '0; host_cs_n = 1'b1; base_sel = '0; cs_qual = 1'b0;
    host_rd = 1'b0; host_wr = 1'b0; host_wdata = '0; dp_rd_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: reset contents on both visible pages
    b = base_of(0);
    for (int o = 0; o < 16; o++) rd_at(b + o, "R10");

    // R5 and R1: fill page 0 while stepping through every base select
    for (int o = 1; o < 16; o++) begin
      cur_sel = o % 8;
      wr_at(base_of(cur_sel) + o, (o * 37) ^ 'h5A, "R5");
    end
    for (int s = 0; s < 8; s++) begin
      cur_sel = s;
      for (int o = 1; o < 16; o += 3) rd_at(base_of(s) + o, "R1");
      // R1: neighbouring blocks and another base miss
      rd_at(base_of(s) + 'h20 + 1, "R1");
      rd_at(base_of((s + 1) % 8) + 2, "R1");
    end

    // R9: writes that miss leave the registers alone
    cur_sel = 7;
    wr_at('h220 + 3, 'hEE, "R9");
    wr_at('h300 + 3, 'hEE, "R9");
    rd_at('h200 + 3, "R9");

    // R2: chip-select qualification
    cur_csq = 1'b1;
    cyc('h204, 1'b0, 1'b1, 'h77, 1'b1, "R2");
    cyc('h204, 1'b1, 1'b0, 0, 1'b0, "R2");
    cyc('h304, 1'b1, 1'b0, 0, 1'b0, "R2");
    cyc('h204, 1'b0, 1'b1, 'h66, 1'b0, "R2");
    cur_csq = 1'b0;
    cyc('h204, 1'b1, 1'b0, 0, 1'b1, "R2");

    // R3, R12: switch to page 1, access it the very next cycle
    wr_at('h200, 'h40, "R12");
    rd_at('h201, "R12");
    rd_at('h200, "R3");
    for (int o = 1; o < 16; o++) wr_at('h200 + o, 'hA0 + o, "R6");
    for (int o = 1; o < 16; o++) rd_at('h200 + o, "R6");

    // R5: page 0 is unchanged after page-1 traffic
    wr_at('h200, 'h15, "R3");
    for (int o = 1; o < 16; o++) rd_at('h200 + o, "R5");

    // R4: undefined page codes read zero and drop writes
    wr_at('h200, 'h80, "R4");
    for (int o = 1; o < 16; o += 2) begin wr_at('h200 + o, 'h99, "R4"); rd_at('h200 + o, "R4"); end
    wr_at('h200, 'hC3, "R4");
    wr_at('h205, 'h98, "R4");
    rd_at('h205, "R4");
    rd_at('h200, "R3");
    wr_at('h200, 'h00, "R4");
    rd_at('h205, "R4");
    wr_at('h200, 'h41, "R4");
    rd_at('h205, "R4");

    // R7: data-port window
    for (int o = 16; o < 18; o++) begin
      rd_at('h200 + o, "R7");
      wr_at('h200 + o, 'h5C, "R7");
    end
    cyc('h211, 1'b1, 1'b1, 'h33, 1'b0, "R7");
    rd_at('h200, "R7");
    for (int o = 1; o < 8; o++) rd_at('h200 + o, "R7");

    // R8: reserved upper offsets
    for (int o = 18; o < 32; o++) begin
      wr_at('h200 + o, 'h11 * (o % 8), "R8");
      rd_at('h200 + o, "R8");
    end
    rd_at('h200, "R8");

    // R11: read and write in the same cycle
    cyc('h200, 1'b1, 1'b1, 'h02, 1'b0, "R11");
    rd_at('h200, "R11");
    cyc('h209, 1'b1, 1'b1, 'hBE, 1'b0, "R11");
    rd_at('h209, "R11");
    cyc('h203, 1'b1, 1'b1, 'h4D, 1'b0, "R11");
    rd_at('h203, "R11");

    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    repeat (2) @(posedge clk);
    summary();
  end
endmodule